// File: doc/BRIEF.md
# Accumulator Memory-Reference Instruction Executor

This block carries out the six memory-reference operations of a word-oriented accumulator machine. It owns the accumulator, the link bit and the program counter. The effective address is always resolved before it reaches the block. A caller pulses `start` with a 3-bit opcode, the effective address and an indirect flag. The block then runs the operation against a synchronous single-port memory. It raises `done` for one cycle when the updated registers are visible, and it reports the architectural memory-cycle count of the operation in `instr_cycles`. The indirect flag only changes that count.

Opcode encoding: 0 is logical AND, 1 is two's-complement add, 2 is increment-and-skip-if-zero, 3 is deposit-and-clear, 4 is subroutine call, 5 is jump. The program counter holds the address of the instruction being executed. Operations that are not jumps leave it on the following word. A separate interrupt entry saves the program counter at word 0 and continues from word 1. Memory reads return data on `mem_rdata` in the cycle after `mem_rd` is high. Writes take effect at the clock edge that ends a cycle in which `mem_wr` is high.

Top module: `mri_exec`

## Requirements
- R1: Opcode 0 replaces the accumulator with the bitwise AND of the accumulator and the addressed word. Memory is left unchanged and the program counter advances by one.
- R2: Opcode 1 adds the addressed word to the accumulator modulo 2^W. A carry out of the top bit complements the link. Memory is unchanged and the program counter advances by one.
- R3: Opcode 3 writes the accumulator to the addressed word, then clears the accumulator. The program counter advances by one.
- R4: Opcode 2 writes the addressed word plus one back to the same word and leaves the accumulator unchanged. If the written value is zero, the program counter advances by two; otherwise it advances by one.
- R5: Opcode 5 loads the effective address into the program counter. The accumulator and memory are unchanged.
- R6: Opcode 4 writes the program counter plus one (the return address) to the effective address, then loads the effective address plus one into the program counter.
- R7: All program counter arithmetic wraps modulo 2^W, so an all-ones value advances to zero.
- R8: With `done`, `instr_cycles` reports 1 for opcode 5 and 2 for every other opcode. One is added when the indirect flag was set with the start.
- R9: An interrupt pulse accepted while idle writes the program counter to word 0 and sets the program counter to 1. It reports 1 cycle and changes neither the accumulator nor the link. When the interrupt and `start` arrive in the same cycle, the interrupt wins and the start is dropped.
- R10: A `start` pulse while `busy` is high, or one carrying opcode 6 or 7, is ignored. No operation is launched and no register changes.
- R11: After reset the accumulator, link and program counter are zero, and `busy`, `done`, `mem_rd` and `mem_wr` are low. `mem_rd` and `mem_wr` are never high together.
- R12: Only opcode 1 may change the link. Every other opcode and the interrupt entry leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Launch an operation when idle |
| opcode | input | 3 | Operation code sampled with start |
| eff_addr | input | W | Resolved effective address |
| indirect | input | 1 | Operation used indirect addressing (timing only) |
| irq | input | 1 | Interrupt entry request |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle pulse, results are visible |
| instr_cycles | output | 2 | Memory-cycle count of the completed operation |
| acc | output | W | Accumulator |
| link | output | 1 | Link bit |
| prog_ctr | output | W | Program counter |
| mem_addr | output | W | Memory address |
| mem_rd | output | 1 | Memory read request |
| mem_wr | output | 1 | Memory write request |
| mem_wdata | output | W | Memory write data |
| mem_rdata | input | W | Memory read data, one cycle after mem_rd |

## Verification
The bench builds the block with a word width of 6 bits, which gives 64 memory words and 64 possible data values. At that width an add sweep over every accumulator and memory pair, including every carry into the link, is short enough to run. An AND sweep over a large part of the same space is also affordable. The small width also brings program counter wrap, skip-to-zero and a subroutine call at the top address within a few instructions.

// File: rtl/mri_pkg.sv
// Shared types for the memory-reference executor.
// Assumes a 3-bit opcode field; values 6 and 7 are not operations of this block.
package mri_pkg;

    localparam int OPC_W = 3;
    localparam int CYC_W = 2;

    typedef enum logic [OPC_W-1:0] {
        OP_AND = 3'd0,
        OP_TAD = 3'd1,
        OP_ISZ = 3'd2,
        OP_DCA = 3'd3,
        OP_JMS = 3'd4,
        OP_JMP = 3'd5
    } op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ,
        ST_EXEC,
        ST_WRITE,
        ST_JUMP
    } st_e;

endpackage

// File: rtl/mri_seq.sv
// Sequencer: steps one operation through read, execute, write or jump states.
// Assumes the caller latches opcode/address on accept_op and supplies the latched op.
module mri_seq
    import mri_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             irq,
    input  logic [OPC_W-1:0] opcode,
    input  logic [OPC_W-1:0] op_q,
    output st_e              state,
    output logic             accept_op,
    output logic             accept_irq,
    output logic             commit
);

    st_e  state_nx;
    logic idle;
    logic legal;

    // Decode acceptance of new work from the idle state.
    always_comb begin
        idle       = (state == ST_IDLE);
        legal      = (opcode <= OPC_W'(OP_JMP));
        accept_irq = idle && irq;
        accept_op  = idle && start && !irq && legal;
    end

    // Choose the next state and flag the cycle that commits results.
    always_comb begin
        state_nx = state;
        commit   = 1'b0;
        case (state)
            ST_IDLE: begin
                if (accept_irq) begin
                    state_nx = ST_WRITE;
                end else if (accept_op) begin
                    case (opcode)
                        OPC_W'(OP_AND), OPC_W'(OP_TAD), OPC_W'(OP_ISZ): state_nx = ST_READ;
                        OPC_W'(OP_DCA), OPC_W'(OP_JMS):                 state_nx = ST_WRITE;
                        default:                                         state_nx = ST_JUMP;
                    endcase
                end
            end
            ST_READ: state_nx = ST_EXEC;
            ST_EXEC: begin
                if (op_q == OPC_W'(OP_ISZ)) begin
                    state_nx = ST_WRITE;
                end else begin
                    state_nx = ST_IDLE;
                    commit   = 1'b1;
                end
            end
            ST_WRITE: begin
                state_nx = ST_IDLE;
                commit   = 1'b1;
            end
            ST_JUMP: begin
                state_nx = ST_IDLE;
                commit   = 1'b1;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // State register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

endmodule

// File: rtl/mri_alu.sv
// Data path: accumulator/link results and the memory increment value.
// Assumes rdata is valid only in the execute state; callers ignore it elsewhere.
module mri_alu
    import mri_pkg::*;
#(
    parameter int W = 12
) (
    input  logic [OPC_W-1:0] op,
    input  logic [W-1:0]     ac,
    input  logic             lnk,
    input  logic [W-1:0]     rdata,
    output logic [W-1:0]     ac_nx,
    output logic             lnk_nx,
    output logic [W-1:0]     inc_val,
    output logic             inc_zero
);

    logic [W:0] sum;

    // Compute the accumulator and link outcome for the current op.
    always_comb begin
        sum    = {1'b0, ac} + {1'b0, rdata};
        ac_nx  = ac;
        lnk_nx = lnk;
        case (op)
            OPC_W'(OP_AND): ac_nx = ac & rdata;
            OPC_W'(OP_TAD): begin
                ac_nx  = sum[W-1:0];
                lnk_nx = lnk ^ sum[W];
            end
            OPC_W'(OP_DCA): ac_nx = '0;
            default: ac_nx = ac;
        endcase
    end

    // Memory word plus one, and its zero test for the skip decision.
    always_comb begin
        inc_val  = rdata + W'(1);
        inc_zero = (inc_val == '0);
    end

endmodule

// File: rtl/mri_pc_next.sv
// Program counter successor selection for every operation and the interrupt.
// Assumes pc holds the address of the operation being executed.
module mri_pc_next
    import mri_pkg::*;
#(
    parameter int W       = 12,
    parameter int IRQ_VEC = 1
) (
    input  logic [OPC_W-1:0] op,
    input  logic [W-1:0]     pc,
    input  logic [W-1:0]     ea,
    input  logic             skip,
    input  logic             is_irq,
    output logic [W-1:0]     pc_nx,
    output logic [W-1:0]     pc_inc
);

    localparam logic [W-1:0] VEC = W'(IRQ_VEC);

    // Select the next program counter value, all sums modulo 2^W.
    always_comb begin
        pc_inc = pc + W'(1);
        if (is_irq) begin
            pc_nx = VEC;
        end else begin
            case (op)
                OPC_W'(OP_JMP): pc_nx = ea;
                OPC_W'(OP_JMS): pc_nx = ea + W'(1);
                OPC_W'(OP_ISZ): pc_nx = skip ? pc + W'(2) : pc_inc;
                default:        pc_nx = pc_inc;
            endcase
        end
    end

endmodule

// File: rtl/mri_exec.sv
// Top: executes one memory-reference operation per start pulse, or an interrupt entry.
// Assumes a synchronous memory whose read data arrives the cycle after mem_rd.
module mri_exec
    import mri_pkg::*;
#(
    parameter int W         = 12,
    parameter int SAVE_ADDR = 0,
    parameter int IRQ_VEC   = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [2:0]       opcode,
    input  logic [W-1:0]     eff_addr,
    input  logic             indirect,
    input  logic             irq,
    output logic             busy,
    output logic             done,
    output logic [1:0]       instr_cycles,
    output logic [W-1:0]     acc,
    output logic             link,
    output logic [W-1:0]     prog_ctr,
    output logic [W-1:0]     mem_addr,
    output logic             mem_rd,
    output logic             mem_wr,
    output logic [W-1:0]     mem_wdata,
    input  logic [W-1:0]     mem_rdata
);

    localparam logic [W-1:0] SAVE = W'(SAVE_ADDR);

    st_e              state;
    logic             accept_op;
    logic             accept_irq;
    logic             commit;
    logic [OPC_W-1:0] op_q;
    logic [W-1:0]     ea_q;
    logic             ind_q;
    logic             irq_q;
    logic             zero_q;
    logic [W-1:0]     wdata_q;
    logic [W-1:0]     ac_nx;
    logic             lnk_nx;
    logic [W-1:0]     inc_val;
    logic             inc_zero;
    logic [W-1:0]     pc_nx;
    logic [W-1:0]     pc_inc;
    logic [CYC_W-1:0] cyc_calc;

    mri_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .irq        (irq),
        .opcode     (opcode),
        .op_q       (op_q),
        .state      (state),
        .accept_op  (accept_op),
        .accept_irq (accept_irq),
        .commit     (commit)
    );

    mri_alu #(.W(W)) u_alu (
        .op       (op_q),
        .ac       (acc),
        .lnk      (link),
        .rdata    (mem_rdata),
        .ac_nx    (ac_nx),
        .lnk_nx   (lnk_nx),
        .inc_val  (inc_val),
        .inc_zero (inc_zero)
    );

    mri_pc_next #(.W(W), .IRQ_VEC(IRQ_VEC)) u_pc (
        .op     (op_q),
        .pc     (prog_ctr),
        .ea     (ea_q),
        .skip   (zero_q),
        .is_irq (irq_q),
        .pc_nx  (pc_nx),
        .pc_inc (pc_inc)
    );

    // Memory port and status driven from registered state.
    always_comb begin
        busy      = (state != ST_IDLE);
        mem_rd    = (state == ST_READ);
        mem_wr    = (state == ST_WRITE);
        mem_addr  = (irq_q && state == ST_WRITE) ? SAVE : ea_q;
        mem_wdata = wdata_q;
    end

    // Architectural memory-cycle count for the operation in flight.
    always_comb begin
        if (irq_q) begin
            cyc_calc = CYC_W'(1);
        end else begin
            cyc_calc = ((op_q == OPC_W'(OP_JMP)) ? CYC_W'(1) : CYC_W'(2)) + CYC_W'(ind_q);
        end
    end

    // Latch operands, stage write data and commit architectural state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q         <= '0;
            ea_q         <= '0;
            ind_q        <= 1'b0;
            irq_q        <= 1'b0;
            zero_q       <= 1'b0;
            wdata_q      <= '0;
            acc          <= '0;
            link         <= 1'b0;
            prog_ctr     <= '0;
            done         <= 1'b0;
            instr_cycles <= '0;
        end else begin
            done <= 1'b0;
            if (accept_irq) begin
                irq_q   <= 1'b1;
                ind_q   <= 1'b0;
                wdata_q <= prog_ctr;
            end else if (accept_op) begin
                irq_q   <= 1'b0;
                op_q    <= opcode;
                ea_q    <= eff_addr;
                ind_q   <= indirect;
                wdata_q <= (opcode == OPC_W'(OP_DCA)) ? acc : pc_inc;
            end
            if (state == ST_EXEC) begin
                wdata_q <= inc_val;
                zero_q  <= inc_zero;
            end
            if (commit) begin
                done         <= 1'b1;
                instr_cycles <= cyc_calc;
                prog_ctr     <= pc_nx;
                if (!irq_q) begin
                    acc  <= ac_nx;
                    link <= lnk_nx;
                end
            end
        end
    end

endmodule

// File: rtl/mri_exec_chk.sv
// Property checker for mri_exec, attached by bind; observes ports and latched operands.
module mri_exec_chk
    import mri_pkg::*;
#(
    parameter int W = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             done,
    input logic             irq_q,
    input logic [OPC_W-1:0] op_q,
    input logic [W-1:0]     ea_q,
    input logic [W-1:0]     acc,
    input logic             link,
    input logic [W-1:0]     prog_ctr,
    input logic [W-1:0]     mem_addr,
    input logic             mem_rd,
    input logic             mem_wr,
    input logic [W-1:0]     mem_wdata,
    input logic [W-1:0]     mem_rdata
);

    a_r11_rd_wr_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

    a_r1_and_result: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !irq_q && op_q == OPC_W'(OP_AND)) |-> acc == ($past(acc) & $past(mem_rdata)));

    a_r2_add_carry: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !irq_q && op_q == OPC_W'(OP_TAD)) |->
        ({link ^ $past(link), acc} == ({1'b0, $past(acc)} + {1'b0, $past(mem_rdata)})));

    a_r3_deposit_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !irq_q && op_q == OPC_W'(OP_DCA)) |->
        (acc == '0 && $past(mem_wr) && $past(mem_wdata) == $past(acc)));

    a_r5_jump_target: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !irq_q && op_q == OPC_W'(OP_JMP)) |-> prog_ctr == ea_q);

    a_r9_irq_save: assert property (@(posedge clk) disable iff (!rst_n)
        (done && irq_q) |-> (prog_ctr == W'(1) && $past(mem_wr) && $past(mem_addr) == '0));

    a_r12_link_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (done && (irq_q || op_q != OPC_W'(OP_TAD))) |-> link == $past(link));

endmodule

bind mri_exec mri_exec_chk #(.W(W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .done      (done),
    .irq_q     (irq_q),
    .op_q      (op_q),
    .ea_q      (ea_q),
    .acc       (acc),
    .link      (link),
    .prog_ctr  (prog_ctr),
    .mem_addr  (mem_addr),
    .mem_rd    (mem_rd),
    .mem_wr    (mem_wr),
    .mem_wdata (mem_wdata),
    .mem_rdata (mem_rdata)
);

// File: tb/mri_exec_test.sv
module mri_exec_test;

    localparam int TW     = 6;
    localparam int DEPTH  = 1 << TW;
    localparam int CLK_P  = 10;
    localparam int WD_MAX = 190000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [2:0]    opcode = '0;
    logic [TW-1:0] eff_addr = '0;
    logic          indirect = 1'b0;
    logic          irq = 1'b0;
    logic          busy;
    logic          done;
    logic [1:0]    instr_cycles;
    logic [TW-1:0] acc;
    logic          link;
    logic [TW-1:0] prog_ctr;
    logic [TW-1:0] mem_addr;
    logic          mem_rd;
    logic          mem_wr;
    logic [TW-1:0] mem_wdata;
    logic [TW-1:0] mem_rdata;

    logic [TW-1:0] mem [0:DEPTH-1];
    logic          host_we = 1'b0;
    logic [TW-1:0] host_addr = '0;
    logic [TW-1:0] host_data = '0;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    logic [TW-1:0] m_ac = '0;
    logic          m_lk = 1'b0;
    logic [TW-1:0] m_pc = '0;

    always #(CLK_P/2) clk = ~clk;

    mri_exec #(.W(TW)) uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (start),
        .opcode       (opcode),
        .eff_addr     (eff_addr),
        .indirect     (indirect),
        .irq          (irq),
        .busy         (busy),
        .done         (done),
        .instr_cycles (instr_cycles),
        .acc          (acc),
        .link         (link),
        .prog_ctr     (prog_ctr),
        .mem_addr     (mem_addr),
        .mem_rd       (mem_rd),
        .mem_wr       (mem_wr),
        .mem_wdata    (mem_wdata),
        .mem_rdata    (mem_rdata)
    );

    // Synchronous memory model with a bench-side write port.
    always @(posedge clk) begin
        if (mem_wr) mem[mem_addr] <= mem_wdata;
        if (host_we) mem[host_addr] <= host_data;
        if (mem_rd) mem_rdata <= mem[mem_addr];
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic poke(input logic [TW-1:0] a, input logic [TW-1:0] d);
        @(negedge clk);
        host_we = 1'b1; host_addr = a; host_data = d;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic wait_done(input string tag);
        int n = 0;
        while (!done && n < 20) begin
            @(negedge clk);
            n++;
        end
        chk(done, tag, int'(done), 1);
    endtask

    // Launch one operation, predict its effect and compare at the ports.
    task automatic do_op(input logic [2:0] op, input logic [TW-1:0] ea, input bit ind);
        logic [TW-1:0] m;
        logic [TW:0]   s;
        logic [TW-1:0] r;
        int            cyc;
        m = mem[ea];
        @(negedge clk);
        start = 1'b1; opcode = op; eff_addr = ea; indirect = ind;
        @(negedge clk);
        start = 1'b0;
        wait_done("R8 done");
        cyc = ((op == 3'd5) ? 1 : 2) + int'(ind);
        chk(instr_cycles == 2'(cyc), "R8 cycles", int'(instr_cycles), cyc);
        case (op)
            3'd0: begin
                m_ac = m_ac & m;
                m_pc = m_pc + 1'b1;
                chk(mem[ea] == m, "R1 mem", int'(mem[ea]), int'(m));
            end
            3'd1: begin
                s = {1'b0, m_ac} + {1'b0, m};
                m_ac = s[TW-1:0];
                m_lk = m_lk ^ s[TW];
                m_pc = m_pc + 1'b1;
                chk(mem[ea] == m, "R2 mem", int'(mem[ea]), int'(m));
            end
            3'd2: begin
                r = m + 1'b1;
                chk(mem[ea] == r, "R4 writeback", int'(mem[ea]), int'(r));
                m_pc = m_pc + ((r == '0) ? TW'(2) : TW'(1));
            end
            3'd3: begin
                chk(mem[ea] == m_ac, "R3 store", int'(mem[ea]), int'(m_ac));
                m_ac = '0;
                m_pc = m_pc + 1'b1;
            end
            3'd4: begin
                r = m_pc + 1'b1;
                chk(mem[ea] == r, "R6 return addr", int'(mem[ea]), int'(r));
                m_pc = ea + 1'b1;
            end
            default: begin
                chk(mem[ea] == m, "R5 mem", int'(mem[ea]), int'(m));
                m_pc = ea;
            end
        endcase
        chk(acc == m_ac, "R1-R6 acc", int'(acc), int'(m_ac));
        chk(link == m_lk, "R12 link", int'(link), int'(m_lk));
        chk(prog_ctr == m_pc, "R7 pc", int'(prog_ctr), int'(m_pc));
    endtask

    // Make the accumulator hold v (clears via deposit, then adds v).
    task automatic set_ac(input logic [TW-1:0] v);
        do_op(3'd3, TW'(60), 1'b0);
        poke(TW'(61), v);
        do_op(3'd1, TW'(61), 1'b0);
    endtask

    initial begin
        repeat (WD_MAX) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [TW-1:0] save_pc;
        logic [TW-1:0] save_ac;
        logic          save_lk;
        bit            seen;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11: reset state
        chk(acc == '0 && link == 1'b0 && prog_ctr == '0, "R11 regs", int'(acc), 0);
        chk(!busy && !done && !mem_rd && !mem_wr, "R11 ctrl", int'({busy, done, mem_rd, mem_wr}), 0);

        // R2: full add sweep over every accumulator/memory pair
        for (int a = 0; a < DEPTH; a++) begin
            for (int b = 0; b < DEPTH; b++) begin
                set_ac(TW'(a));
                poke(TW'(62), TW'(b));
                do_op(3'd1, TW'(62), 1'b0);
            end
        end

        // R1: AND sweep
        for (int a = 0; a < DEPTH; a += 5) begin
            for (int b = 0; b < DEPTH; b++) begin
                set_ac(TW'(a));
                poke(TW'(62), TW'(b));
                do_op(3'd0, TW'(62), (b % 2) == 1);
            end
        end

        // R4: increment sweep including the zero-skip case; R8 indirect counts
        for (int b = 0; b < DEPTH; b++) begin
            poke(TW'(20), TW'(b));
            do_op(3'd2, TW'(20), (b % 3) == 0);
        end

        // R3 and R5, R6, R7: deposit, jumps, subroutine call and wrap
        set_ac(TW'(45));
        do_op(3'd3, TW'(21), 1'b1);
        do_op(3'd5, TW'(DEPTH - 1), 1'b0);
        do_op(3'd0, TW'(21), 1'b0);
        chk(prog_ctr == '0, "R7 wrap", int'(prog_ctr), 0);
        do_op(3'd5, TW'(DEPTH - 2), 1'b1);
        poke(TW'(22), TW'(DEPTH - 1));
        do_op(3'd2, TW'(22), 1'b0);
        chk(prog_ctr == '0, "R7 skip wrap", int'(prog_ctr), 0);
        do_op(3'd4, TW'(30), 1'b0);
        do_op(3'd4, TW'(DEPTH - 1), 1'b1);
        chk(prog_ctr == '0, "R6 R7 call at top", int'(prog_ctr), 0);

        // R9: interrupt entry
        set_ac(TW'(27));
        do_op(3'd5, TW'(13), 1'b0);
        save_ac = m_ac;
        save_lk = m_lk;
        @(negedge clk);
        irq = 1'b1;
        @(negedge clk);
        irq = 1'b0;
        wait_done("R9 done");
        chk(mem[0] == TW'(13), "R9 saved pc", int'(mem[0]), 13);
        chk(prog_ctr == TW'(1), "R9 pc", int'(prog_ctr), 1);
        chk(instr_cycles == 2'd1, "R9 cycles", int'(instr_cycles), 1);
        chk(acc == save_ac && link == save_lk, "R9 R12 acc link", int'(acc), int'(save_ac));
        m_pc = TW'(1);

        // R9: interrupt beats a simultaneous start
        do_op(3'd5, TW'(40), 1'b0);
        @(negedge clk);
        irq = 1'b1; start = 1'b1; opcode = 3'd5; eff_addr = TW'(9);
        @(negedge clk);
        irq = 1'b0; start = 1'b0;
        wait_done("R9 done");
        chk(mem[0] == TW'(40), "R9 priority save", int'(mem[0]), 40);
        repeat (4) @(negedge clk);
        chk(!busy && prog_ctr == TW'(1), "R9 start dropped", int'(prog_ctr), 1);
        m_pc = TW'(1);

        // R10: start while busy is ignored
        poke(TW'(23), TW'(5));
        @(negedge clk);
        start = 1'b1; opcode = 3'd1; eff_addr = TW'(23); indirect = 1'b0;
        @(negedge clk);
        opcode = 3'd5; eff_addr = TW'(33);
        @(negedge clk);
        start = 1'b0;
        wait_done("R10 done");
        begin
            logic [TW:0] s;
            s = {1'b0, m_ac} + {1'b0, TW'(5)};
            m_ac = s[TW-1:0];
            m_lk = m_lk ^ s[TW];
        end
        m_pc = m_pc + 1'b1;
        repeat (4) @(negedge clk);
        chk(prog_ctr == m_pc && !busy, "R10 busy start", int'(prog_ctr), int'(m_pc));
        chk(acc == m_ac, "R10 acc", int'(acc), int'(m_ac));

        // R10: opcodes 6 and 7 are ignored
        for (int k = 6; k < 8; k++) begin
            save_pc = prog_ctr;
            seen = 1'b0;
            @(negedge clk);
            start = 1'b1; opcode = 3'(k); eff_addr = TW'(3);
            @(negedge clk);
            start = 1'b0;
            for (int t = 0; t < 4; t++) begin
                if (busy || done) seen = 1'b1;
                @(negedge clk);
            end
            chk(!seen, "R10 illegal opcode", int'(seen), 0);
            chk(prog_ctr == save_pc && acc == m_ac, "R10 regs held", int'(prog_ctr), int'(save_pc));
        end

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule